// File: doc/BRIEF.md
# Lookup-Table Trigger Decision Unit

This block makes the final trigger decision from a vector of physical trigger bits. The vector is used as a bit address into a lookup table. The table holds the truth table of an arbitrary Boolean function of those bits. The decision is registered and leaves the block one clock after the vector is sampled.

Software programs the table through a simple 16-bit register port. The table occupies consecutive word registers starting at offset 100h. Its length follows from the number of trigger inputs: a single word when there are four or fewer inputs, otherwise 2^(N-4) words. Some fixed identification and sizing values can also be read through the same port.

With eight inputs (the default), the inputs are:

- bits 4:0: individual detector triggers
- bit 5: the combined calorimeter trigger
- bits 7:6: two laser lines

Top module: `lut_trigger_unit`

## Requirements
- R1: A read at offset 000h returns bits 15:0 of the 32-bit identification value, and a read at 001h returns bits 31:16.
- R2: A read at offset 004h returns the input channel count, and a read at 005h returns the physical trigger count N.
- R3: Offset 100h+k, for k below the word count, is a read/write 16-bit table word; a written value reads back unchanged from the next cycle on.
- R4: The word count is 1 when N is 4 or fewer, and 2^(N-4) otherwise. Writes to 100h+count up to 1FFh change nothing, and reads there return 0.
- R5: Trigger bits [N-1:4] select the table word, and bits [3:0] select the bit within it (bit 0 is the LSB). The decision equals that table bit.
- R6: The decision output is registered. It shows the table bit for the vector present at the previous rising clock edge.
- R7: A table write takes effect on the next cycle. A lookup in the same cycle as a write to its word uses the old content.
- R8: After reset every table word is 0 and the decision is 0.
- R9: Writes to any offset outside the table have no effect. Reads from unassigned offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | NTRIG | Physical trigger vector, sampled every cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| decision | output | 1 | Registered trigger decision |

## Verification
A table write and a lookup that lands on the very word being written can fall in the same cycle. The bench provokes this by driving a write to the word that the current trigger vector addresses, with inverted content. The scoreboard then expects the old bit in that cycle and the new bit one cycle later (R7). The bench also sweeps all 256 trigger vectors against its own model of the table. It probes writes outside the table window and checks that they leave readback and decisions untouched.

// File: rtl/lut_trigger_unit.sv
module lut_trigger_unit #(
  parameter int          NTRIG = 8,
  parameter int          NCHAN = 17,
  parameter logic [31:0] ID    = 32'hC0DE_7A11,
  parameter int          AW    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIG-1:0] trig_in,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  output logic             decision
);
  localparam int WORDS    = (NTRIG <= 4) ? 1 : (1 << (NTRIG - 4));
  localparam int WSEL     = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int LUT_BASE = 'h100;

  logic [15:0]     lut [WORDS];
  logic [AW-1:0]   offs;
  logic            lut_hit;
  logic [WSEL-1:0] wsel;
  logic [WSEL-1:0] word_idx;
  logic [3:0]      bit_idx;

  assign offs    = reg_addr - AW'(LUT_BASE);
  assign lut_hit = (reg_addr >= AW'(LUT_BASE)) && (offs < AW'(WORDS));
  assign wsel    = offs[WSEL-1:0];

  generate
    if (NTRIG > 4) begin : g_multi
      assign word_idx = trig_in[NTRIG-1:4];
      assign bit_idx  = trig_in[3:0];
    end else begin : g_single
      assign word_idx = '0;
      assign bit_idx  = 4'(trig_in);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) lut[i] <= '0;
      decision <= 1'b0;
    end else begin
      decision <= lut[word_idx][bit_idx];
      if (reg_wr && lut_hit) lut[wsel] <= reg_wdata;
    end
  end

  always_comb begin
    if (lut_hit) reg_rdata = lut[wsel];
    else begin
      case (reg_addr)
        AW'(0):  reg_rdata = ID[15:0];
        AW'(1):  reg_rdata = ID[31:16];
        AW'(4):  reg_rdata = 16'(NCHAN);
        AW'(5):  reg_rdata = 16'(NTRIG);
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/lut_trigger_unit_chk.sv
module lut_trigger_unit_chk #(
  parameter int          NTRIG = 8,
  parameter int          NCHAN = 17,
  parameter logic [31:0] ID    = 32'hC0DE_7A11,
  parameter int          AW    = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NTRIG-1:0] trig_in,
  input logic             reg_wr,
  input logic [AW-1:0]    reg_addr,
  input logic [15:0]      reg_wdata,
  input logic [15:0]      reg_rdata,
  input logic             decision
);
  localparam int WORDS = (NTRIG <= 4) ? 1 : (1 << (NTRIG - 4));

  // R1
  id_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(0)) |-> (reg_rdata == ID[15:0]));

  // R2
  trig_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(5)) |-> (reg_rdata == 16'(NTRIG)));

  // R3
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr >= AW'('h100) && reg_addr < AW'('h100 + WORDS))
    |=> ((reg_addr == $past(reg_addr)) |-> (reg_rdata == $past(reg_wdata))));

  // R4
  beyond_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= AW'('h100 + WORDS) && reg_addr <= AW'('h1FF)) |-> (reg_rdata == 16'h0));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(trig_in) && !$past(reg_wr)) |=> $stable(decision));
endmodule

bind lut_trigger_unit lut_trigger_unit_chk #(
  .NTRIG(NTRIG), .NCHAN(NCHAN), .ID(ID), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .decision(decision)
);

// File: tb/test_lut_trigger_unit.sv
module test_lut_trigger_unit;
  localparam int          NTRIG = 8;
  localparam int          NCHAN = 17;
  localparam logic [31:0] ID    = 32'hC0DE_7A11;
  localparam int          AW    = 9;
  localparam int          WORDS = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NTRIG-1:0] trig_in = '0;
  logic             reg_wr = 1'b0;
  logic [AW-1:0]    reg_addr = '0;
  logic [15:0]      reg_wdata = '0;
  logic [15:0]      reg_rdata;
  logic             decision;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [WORDS];
  bit  exp_q [$];
  string tag_q [$];

  always #5 clk = ~clk;

  lut_trigger_unit #(.NTRIG(NTRIG), .NCHAN(NCHAN), .ID(ID), .AW(AW)) i_lut_trigger_unit (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .decision(decision));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a >= AW'('h100) && a < AW'('h100 + WORDS)) model[a - AW'('h100)] = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [AW-1:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    #1 check(reg_rdata == exp, req, 32'(reg_rdata), 32'(exp));
  endtask

  // driver: one lookup per cycle, optional write in the same cycle
  task automatic drive(input logic [NTRIG-1:0] t, input bit wr, input logic [AW-1:0] a,
                       input logic [15:0] d, input string req);
    @(negedge clk);
    trig_in = t; reg_wr = wr; reg_addr = a; reg_wdata = d;
    exp_q.push_back(model[t[7:4]][t[3:0]]);
    tag_q.push_back(req);
    if (wr && a >= AW'('h100) && a < AW'('h100 + WORDS)) model[a - AW'('h100)] = d;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        bit e;
        string r;
        e = exp_q.pop_front();
        r = tag_q.pop_front();
        check(decision == e, r, 32'(decision), 32'(e));
      end
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(decision == 1'b0, "R8", 32'(decision), 0);
    rst_n = 1'b1;
    for (int i = 0; i < WORDS; i++) reg_read(AW'('h100 + i), 16'h0, "R8");
    drive(8'hFF, 1'b0, '0, '0, "R8");
    drive(8'h00, 1'b0, '0, '0, "R8");

    // R1, R2
    reg_read(AW'(0), ID[15:0], "R1");
    reg_read(AW'(1), ID[31:16], "R1");
    reg_read(AW'(4), 16'(NCHAN), "R2");
    reg_read(AW'(5), 16'(NTRIG), "R2");

    // R3 program and read back
    for (int k = 0; k < WORDS; k++) reg_write(AW'('h100 + k), 16'(k * 16'h9E37) ^ 16'h5A5A);
    for (int k = 0; k < WORDS; k++) reg_read(AW'('h100 + k), 16'(k * 16'h9E37) ^ 16'h5A5A, "R3");

    // R4 beyond last word
    reg_write(AW'('h110), 16'hFFFF);
    reg_write(AW'('h1FF), 16'hFFFF);
    reg_read(AW'('h110), 16'h0, "R4");
    reg_read(AW'('h1FF), 16'h0, "R4");
    reg_read(AW'('h100), 16'h5A5A, "R4");
    reg_read(AW'('h10F), 16'(15 * 16'h9E37) ^ 16'h5A5A, "R4");

    // R9 writes to fixed / unassigned offsets
    reg_write(AW'(0), 16'h1234);
    reg_write(AW'(3), 16'hBEEF);
    reg_read(AW'(0), ID[15:0], "R9");
    reg_read(AW'(3), 16'h0, "R9");
    reg_read(AW'('h80), 16'h0, "R9");

    // R5, R6 sweep every vector
    for (int t = 0; t < 256; t++) drive(8'(t), 1'b0, '0, '0, "R5");
    for (int t = 255; t >= 0; t -= 7) drive(8'(t), 1'b0, '0, '0, "R6");

    // R6 output does not move before the clock edge
    drive(8'h00, 1'b0, '0, '0, "R6");
    @(negedge clk);
    trig_in = 8'h01;
    #1 check(decision == model[0][0], "R6", 32'(decision), 32'(model[0][0]));
    @(posedge clk); #1;
    check(decision == model[0][1], "R6", 32'(decision), 32'(model[0][1]));

    // R7 write and lookup on the same word in the same cycle
    drive(8'h35, 1'b1, AW'('h103), ~model[3], "R7");
    drive(8'h35, 1'b0, '0, '0, "R7");
    drive(8'h3A, 1'b1, AW'('h103), 16'h0400, "R7");
    drive(8'h3A, 1'b0, '0, '0, "R7");
    // R9 out-of-window write during lookups
    drive(8'h3A, 1'b1, AW'('h120), 16'h0000, "R9");
    drive(8'h3A, 1'b0, '0, '0, "R9");

    @(negedge clk);
    reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule